// File: doc/BRIEF.md
# Three-Wire Serial Configuration Register Port

This block accepts configuration writes over a three-wire serial link: an active-low select, a serial clock and a data line. While select is low the port takes one data bit on each rising serial-clock edge. Bits arrive least significant first: two operation bits, then four address bits, then ten data bits, with data bit 9 arriving last. When select returns high, the port stores the data word in the addressed control register, but only if exactly sixteen bits were received. Every register value is driven out as a parallel bus. The most-used fields are also decoded onto their own outputs.

The three serial lines are sampled in the system clock domain through two-stage synchronizers. Edges are detected after the synchronizers, so the serial clock must be several times slower than the system clock. Each falling edge of select also produces a one-cycle access pulse. Downstream logic uses this pulse to restart a gain-boost timer, whether the frame that follows is kept or not.

The frame tracker is a four-state machine:
- IDLE: select is high.
- SHIFT: fewer than sixteen bits have been taken.
- FULL: exactly sixteen bits have been taken.
- OVER: more than sixteen bits have been taken.

Its transitions are:
- open (IDLE to SHIFT): select falls.
- fill (SHIFT to FULL): the sixteenth rising clock edge arrives.
- abort (SHIFT to IDLE): select rises early.
- overrun (FULL to OVER): a seventeenth rising clock edge arrives.
- commit (FULL to IDLE): select rises and the frame is written.
- discard (OVER to IDLE): select rises and the frame is dropped.

Top module: `tw_cfg_port`

## Requirements
- R1: After reset (rst_n low), the black-level register reads 64 and every other register and decoded field reads 0; access_evt is 0.
- R2: A frame is taken LSB first, one bit per rising sclk while cs_n is low. Frame bits [1:0] are the operation code, bits [5:2] the address and bits [15:6] the data. A 16-bit frame writes its data on the cs_n rise into the register at that address: 0 mode-one, 1 mode-two, 2 mode-three, 3 gain, 4 black level.
- R3: A frame of fewer than 16 bits leaves every register unchanged.
- R4: A frame of more than 16 bits leaves every register unchanged.
- R5: A 16-bit frame addressed to 5 through 15 leaves every register unchanged.
- R6: The operation code value does not affect whether or what is written.
- R7: The gain register keeps only data bits [8:0]; gain_q is 9 bits wide.
- R8: Each falling edge of cs_n produces exactly one single-cycle access_evt pulse, including for frames that are later discarded.
- R9: From the mode-one register: pwr_down is bit 0, blk_rst is bit 1, out_hiz is bit 2, path_sel is bits [5:4] and smp_inv is bit 6.
- R10: cds_gain is mode-three bits [5:4]. Its codes are 0: 0 dB, 1: 6.02 dB, 2: 12.04 dB, 3: -1.94 dB.
- R11: Rising sclk edges while cs_n is high shift no bit in and change no register.
- R12: Registers keep their old values after all 16 bits have arrived, until cs_n rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock; data is taken on its rising edge |
| sdata | input | 1 | Serial data |
| mode1_q | output | 10 | Mode-one register |
| mode2_q | output | 10 | Mode-two register |
| mode3_q | output | 10 | Mode-three register |
| gain_q | output | 9 | Amplifier gain register |
| black_q | output | 10 | Black-level target register |
| pwr_down | output | 1 | Power-down bit of mode one |
| blk_rst | output | 1 | Black-level reset bit of mode one |
| out_hiz | output | 1 | Output high-impedance request of mode one |
| path_sel | output | 2 | Input path select of mode one |
| smp_inv | output | 1 | Sample-clock inversion of mode one |
| cds_gain | output | 2 | Double-sampler gain code of mode three |
| access_evt | output | 1 | One-cycle pulse on each select falling edge |

## Verification
The bench sends frames of 15 and 17 bits to the black-level address. A tracker that counted bits loosely, or that wrote whenever select rose, would overwrite the value 64 that reset left there. It toggles the serial clock while select is high and then sends a normal frame. Edges that leaked into the shifter would misalign that frame and put the data in the wrong register. It writes all-ones data to the gain register and to undefined addresses 7 and 15, and it varies the operation code, so a missing mask or a loose address decode changes a visible bus. It also samples the outputs after the sixteenth bit but before select rises, and checks that each discarded frame still raised exactly one access pulse.

// File: rtl/tw_cfg_pkg.sv
package tw_cfg_pkg;

    localparam int NREG      = 5;
    localparam int DW        = 10;
    localparam int AW        = 4;
    localparam int OPW       = 2;
    localparam int FRAME_LEN = OPW + AW + DW;
    localparam int PAYLOAD_W = AW + DW;
    localparam int GAIN_W    = 9;

    localparam int IDX_MODE1 = 0;
    localparam int IDX_MODE2 = 1;
    localparam int IDX_MODE3 = 2;
    localparam int IDX_GAIN  = 3;
    localparam int IDX_BLACK = 4;

    localparam logic [DW-1:0] BLACK_DEFAULT = 10'd64;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_FULL,
        ST_OVER
    } frame_state_t;

    function automatic logic [DW-1:0] reg_default(input int idx);
        return (idx == IDX_BLACK) ? BLACK_DEFAULT : '0;
    endfunction

    function automatic logic [DW-1:0] reg_mask(input int idx);
        return (idx == IDX_GAIN) ? DW'((1 << GAIN_W) - 1) : '1;
    endfunction

endpackage

// File: rtl/tw_cfg_sync.sv
module tw_cfg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    input  logic sdata,
    output logic sck_rise,
    output logic cs_fall,
    output logic cs_rise,
    output logic sdi,
    output logic evt_q
);
    // lane order: {data, select, clock}
    localparam logic [2:0] RST_VAL = 3'b010;

    logic [2:0] stg [STAGES];
    logic [1:0] prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= RST_VAL;
        else        stg[0] <= {sdata, cs_n, sclk};
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[s] <= RST_VAL;
                else        stg[s] <= stg[s-1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev  <= RST_VAL[1:0];
            evt_q <= 1'b0;
        end else begin
            prev  <= stg[STAGES-1][1:0];
            evt_q <= cs_fall;
        end
    end

    always_comb begin
        sck_rise = stg[STAGES-1][0] & ~prev[0];
        cs_fall  = ~stg[STAGES-1][1] & prev[1];
        cs_rise  = stg[STAGES-1][1] & ~prev[1];
        sdi      = stg[STAGES-1][2];
    end

endmodule

// File: rtl/tw_cfg_frame.sv
module tw_cfg_frame
    import tw_cfg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sck_rise,
    input  logic          cs_fall,
    input  logic          cs_rise,
    input  logic          sdi,
    output logic          commit,
    output logic [AW-1:0] frm_addr,
    output logic [DW-1:0] frm_data
);
    localparam int CW = $clog2(FRAME_LEN);
    localparam logic [CW-1:0] LAST = CW'(FRAME_LEN - 1);

    frame_state_t st, nxt;
    logic [CW-1:0]        cnt;
    logic [PAYLOAD_W-1:0] sr;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // transitions: open, fill, abort, overrun, commit, discard
    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE:  if (cs_fall) nxt = ST_SHIFT;
            ST_SHIFT: begin
                if (cs_rise)                        nxt = ST_IDLE;
                else if (sck_rise && cnt == LAST)   nxt = ST_FULL;
            end
            ST_FULL: begin
                if (cs_rise)       nxt = ST_IDLE;
                else if (sck_rise) nxt = ST_OVER;
            end
            ST_OVER:  if (cs_rise) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // bit counter and payload shifter; opcode bits fall off the low end
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            sr  <= '0;
        end else if (st == ST_IDLE && cs_fall) begin
            cnt <= '0;
        end else if (st == ST_SHIFT && sck_rise && !cs_rise) begin
            cnt <= cnt + 1'b1;
            sr  <= {sdi, sr[PAYLOAD_W-1:1]};
        end
    end

    // outputs
    always_comb begin
        commit   = (st == ST_FULL) && cs_rise;
        frm_addr = sr[AW-1:0];
        frm_data = sr[AW +: DW];
    end

endmodule

// File: rtl/tw_cfg_regs.sv
module tw_cfg_regs
    import tw_cfg_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     commit,
    input  logic [AW-1:0]            frm_addr,
    input  logic [DW-1:0]            frm_data,
    output logic [NREG-1:0]          we_vec,
    output logic [NREG-1:0][DW-1:0]  regs
);
    generate
        for (genvar i = 0; i < NREG; i++) begin : g_reg
            localparam logic [DW-1:0] DEF  = reg_default(i);
            localparam logic [DW-1:0] MASK = reg_mask(i);

            assign we_vec[i] = commit && (frm_addr == AW'(i));

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)         regs[i] <= DEF;
                else if (we_vec[i]) regs[i] <= frm_data & MASK;
            end
        end
    endgenerate

endmodule

// File: rtl/tw_cfg_port.sv
module tw_cfg_port
    import tw_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdata,
    output logic [DW-1:0]     mode1_q,
    output logic [DW-1:0]     mode2_q,
    output logic [DW-1:0]     mode3_q,
    output logic [GAIN_W-1:0] gain_q,
    output logic [DW-1:0]     black_q,
    output logic              pwr_down,
    output logic              blk_rst,
    output logic              out_hiz,
    output logic [1:0]        path_sel,
    output logic              smp_inv,
    output logic [1:0]        cds_gain,
    output logic              access_evt
);
    logic sck_rise, cs_fall, cs_rise, sdi;
    logic commit;
    logic [AW-1:0]           frm_addr;
    logic [DW-1:0]           frm_data;
    logic [NREG-1:0]         we_vec;
    logic [NREG-1:0][DW-1:0] regs;
    logic                    unused_gain_msb;

    tw_cfg_sync #(.STAGES(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk     (sclk),
        .cs_n     (cs_n),
        .sdata    (sdata),
        .sck_rise (sck_rise),
        .cs_fall  (cs_fall),
        .cs_rise  (cs_rise),
        .sdi      (sdi),
        .evt_q    (access_evt)
    );

    tw_cfg_frame u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_rise (sck_rise),
        .cs_fall  (cs_fall),
        .cs_rise  (cs_rise),
        .sdi      (sdi),
        .commit   (commit),
        .frm_addr (frm_addr),
        .frm_data (frm_data)
    );

    tw_cfg_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit   (commit),
        .frm_addr (frm_addr),
        .frm_data (frm_data),
        .we_vec   (we_vec),
        .regs     (regs)
    );

    always_comb begin
        mode1_q         = regs[IDX_MODE1];
        mode2_q         = regs[IDX_MODE2];
        mode3_q         = regs[IDX_MODE3];
        gain_q          = regs[IDX_GAIN][GAIN_W-1:0];
        unused_gain_msb = regs[IDX_GAIN][DW-1];
        black_q         = regs[IDX_BLACK];
        pwr_down        = mode1_q[0];
        blk_rst         = mode1_q[1];
        out_hiz         = mode1_q[2];
        path_sel        = mode1_q[5:4];
        smp_inv         = mode1_q[6];
        cds_gain        = mode3_q[5:4];
    end

endmodule

// File: rtl/tw_cfg_port_sva.sv
module tw_cfg_port_sva
    import tw_cfg_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              access_evt,
    input logic              commit,
    input logic [AW-1:0]     frm_addr,
    input logic [DW-1:0]     frm_data,
    input logic [NREG-1:0]   we_vec,
    input logic [DW-1:0]     mode1_q,
    input logic [DW-1:0]     mode2_q,
    input logic [DW-1:0]     mode3_q,
    input logic [GAIN_W-1:0] gain_q,
    input logic [DW-1:0]     black_q
);
    logic [4*DW+GAIN_W-1:0] all_regs;
    assign all_regs = {mode1_q, mode2_q, mode3_q, gain_q, black_q};

    // R8: access pulse lasts a single cycle
    a_r8_evt_single: assert property (@(posedge clk) disable iff (!rst_n)
        access_evt |=> !access_evt);

    // R12: registers only move on a completed frame
    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(all_regs));

    // R5: undefined address leaves the bank untouched
    a_r5_undef_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && frm_addr >= AW'(NREG)) |=> $stable(all_regs));

    // R2: black-level write lands with the frame data
    a_r2_black_write: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && frm_addr == AW'(IDX_BLACK)) |=> black_q == $past(frm_data));

    // R7: gain keeps the low bits of the data
    a_r7_gain_trim: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && frm_addr == AW'(IDX_GAIN)) |=> gain_q == $past(frm_data[GAIN_W-1:0]));

    // R2: at most one register selected per commit
    a_r2_onehot_we: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(we_vec));

endmodule

bind tw_cfg_port tw_cfg_port_sva u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .access_evt (access_evt),
    .commit     (commit),
    .frm_addr   (frm_addr),
    .frm_data   (frm_data),
    .we_vec     (we_vec),
    .mode1_q    (mode1_q),
    .mode2_q    (mode2_q),
    .mode3_q    (mode3_q),
    .gain_q     (gain_q),
    .black_q    (black_q)
);

// File: tb/tw_cfg_port_test.sv
`timescale 1ns/1ps
module tw_cfg_port_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sclk = 1'b0;
    logic sdata = 1'b0;
    logic [9:0] mode1_q, mode2_q, mode3_q, black_q;
    logic [8:0] gain_q;
    logic pwr_down, blk_rst, out_hiz, smp_inv, access_evt;
    logic [1:0] path_sel, cds_gain;

    always #2 clk = ~clk;

    tw_cfg_port uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdata(sdata),
        .mode1_q(mode1_q), .mode2_q(mode2_q), .mode3_q(mode3_q),
        .gain_q(gain_q), .black_q(black_q), .pwr_down(pwr_down),
        .blk_rst(blk_rst), .out_hiz(out_hiz), .path_sel(path_sel),
        .smp_inv(smp_inv), .cds_gain(cds_gain), .access_evt(access_evt)
    );

    typedef struct packed {
        logic [9:0]  m1;
        logic [9:0]  m2;
        logic [9:0]  m3;
        logic [8:0]  g;
        logic [9:0]  b;
        logic [31:0] ev;
    } snap_t;

    snap_t model;
    snap_t exp_q[$];
    string tag_q[$];
    int    n_checks = 0;
    int    n_fail   = 0;
    int    evt_cnt  = 0;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) if (access_evt) evt_cnt++;

    // monitor: compares the outputs against each queued expectation
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                snap_t e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(t, "mode1", int'(mode1_q), int'(e.m1));
                chk(t, "mode2", int'(mode2_q), int'(e.m2));
                chk(t, "mode3", int'(mode3_q), int'(e.m3));
                chk(t, "gain",  int'(gain_q),  int'(e.g));
                chk(t, "black", int'(black_q), int'(e.b));
                chk("R8", "access events", evt_cnt, int'(e.ev));
                chk("R9", "pwr_down", int'(pwr_down), int'(e.m1[0]));
                chk("R9", "blk_rst",  int'(blk_rst),  int'(e.m1[1]));
                chk("R9", "out_hiz",  int'(out_hiz),  int'(e.m1[2]));
                chk("R9", "path_sel", int'(path_sel), int'(e.m1[5:4]));
                chk("R9", "smp_inv",  int'(smp_inv),  int'(e.m1[6]));
                chk("R10", "cds_gain", int'(cds_gain), int'(e.m3[5:4]));
            end
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic push(input string tag);
        exp_q.push_back(model);
        tag_q.push_back(tag);
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    // driver: shifts nbits of {data, addr, op} LSB first and updates the model
    task automatic send(input string tag, input logic [1:0] op, input logic [3:0] addr,
                        input logic [9:0] data, input int nbits, input bit peek);
        logic [16:0] word;
        word = {1'b0, data, addr, op};
        cs_n = 1'b0;
        wait_clk(6);
        for (int i = 0; i < nbits; i++) begin
            sdata = word[i];
            wait_clk(4);
            sclk = 1'b1;
            wait_clk(4);
            sclk = 1'b0;
            wait_clk(2);
        end
        wait_clk(4);
        if (peek) begin
            @(negedge clk);
            chk("R12", "black before cs rise", int'(black_q), int'(model.b));
        end
        cs_n = 1'b1;
        wait_clk(10);
        model.ev = model.ev + 1;
        if (nbits == 16) begin
            case (addr)
                4'd0: model.m1 = data;
                4'd1: model.m2 = data;
                4'd2: model.m3 = data;
                4'd3: model.g  = data[8:0];
                4'd4: model.b  = data;
                default: ;
            endcase
        end
        push(tag);
    endtask

    task automatic check_defaults(input string tag);
        @(negedge clk);
        chk(tag, "mode1 reset", int'(mode1_q), 0);
        chk(tag, "mode2 reset", int'(mode2_q), 0);
        chk(tag, "mode3 reset", int'(mode3_q), 0);
        chk(tag, "gain reset",  int'(gain_q),  0);
        chk(tag, "black reset", int'(black_q), 64);
        chk(tag, "evt reset",   int'(access_evt), 0);
    endtask

    initial begin
        model = '0;
        model.b = 10'd64;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(3);
        check_defaults("R1");

        // R11: clock edges with select high
        for (int k = 0; k < 5; k++) begin
            sdata = 1'b1;
            sclk = 1'b1; wait_clk(5);
            sclk = 1'b0; wait_clk(5);
        end
        sdata = 1'b0;
        push("R11");

        send("R2", 2'b00, 4'd0, 10'h075, 16, 1'b0);   // mode1, decoded fields
        send("R10", 2'b00, 4'd2, 10'h02A, 16, 1'b0);  // cds code 2
        send("R7", 2'b00, 4'd3, 10'h3FF, 16, 1'b0);   // gain masked
        send("R3", 2'b00, 4'd4, 10'h010, 15, 1'b0);   // short frame
        send("R4", 2'b00, 4'd4, 10'h020, 17, 1'b0);   // long frame
        send("R2", 2'b00, 4'd4, 10'h07F, 16, 1'b1);   // black + R12 peek
        send("R5", 2'b00, 4'd7, 10'h3FF, 16, 1'b0);
        send("R5", 2'b00, 4'd15, 10'h3FF, 16, 1'b0);
        send("R6", 2'b11, 4'd1, 10'h155, 16, 1'b0);
        send("R6", 2'b01, 4'd1, 10'h2AA, 16, 1'b0);
        send("R10", 2'b10, 4'd2, 10'h030, 16, 1'b0);  // cds code 3
        send("R9", 2'b00, 4'd0, 10'h04A, 16, 1'b0);

        rst_n = 1'b0;
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(3);
        check_defaults("R1");

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        wait_clk(200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule